// File: doc/BRIEF.md
# Banked Vectored Interrupt Controller

This block gathers 96 level-sensitive interrupt lines, split into three banks of 32, and merges them into one interrupt request for a processor. Each line has a latched pending bit, an enable bit and a mask bit. A line is active when it is pending, enabled and not masked. The request output goes high one cycle after any line becomes active.

Software reaches the block through a simple 32-bit register bus with a select, a write strobe and a privilege flag. Reading the vector register returns the number of the lowest-numbered active line, shifted left by two. A value of zero means no line needs service, so an interrupt handler reads the vector, services that line, clears its pending bit and repeats until it reads zero. A protection bit can limit all register writes to privileged bus transactions.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every pending, enable and mask bit, the protection bit, the external-control field, the read data and `irq_o` are zero.
- R2: Line n maps to bank n/32, bit n%32. Byte addresses are: vector 0x00, protection 0x08, external control 0x0C, pending bank k at 0x10+4k, enable bank k at 0x40+4k, mask bank k at 0x50+4k. Read data appears on `bus_rdata` in the cycle after the read. Unmapped addresses read as zero.
- R3: A pending bit is set on every clock edge at which its input is high, whatever its enable and mask bits hold.
- R4: Writing a pending bank clears each bit written as one and leaves each bit written as zero unchanged. Writing all ones clears the whole bank for lines whose inputs are low.
- R5: The vector register reads as the selected line number times four.
- R6: A line whose enable bit is clear is never selected and does not raise `irq_o`.
- R7: Among active lines 1 to 95, the lowest number wins the vector. Line 0 is never reported. With no active line from 1 to 95, the vector reads zero.
- R8: A line whose input is still high when its pending bit is cleared stays pending.
- R9: Mask bits are stored and read back. A set mask bit removes the line from the vector and from `irq_o`.
- R10: `irq_o` is a register holding the OR, over all 96 lines including line 0, of pending AND enabled AND NOT masked, taken at the previous clock edge.
- R11: While bit 0 of the protection register is one, writes without `bus_priv` change no register, including the protection register itself. Reads are always served.
- R12: The external-control register stores the low two bits written to it and reads back zero in bits 31:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 96 | Level interrupt inputs, line n on bit n |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access is privileged |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The vector is read with one line active, then with three active lines in different banks to confirm that the lowest wins. It is read again after clearing, after masking and with only line 0 active. The masking and line-0 reads separate "no active line" from "only line 0 active", and only the second of these raises `irq_o`. Pending clears are tried with the input still high and with the input low, using data with both one and zero bits, which separates level re-triggering from clear-on-one behaviour. Protection is tried with unprivileged and privileged writes to an enable bank and to the protection bit itself.

// File: rtl/ivc_pkg.sv
// Shared constants for the banked vectored interrupt controller.
// Assumes byte addressing with 32-bit registers on 4-byte boundaries.
package ivc_pkg;
    localparam int OFS_VEC  = 'h00;
    localparam int OFS_PROT = 'h08;
    localparam int OFS_EXT  = 'h0C;
    localparam int OFS_PEND = 'h10;
    localparam int OFS_EN   = 'h40;
    localparam int OFS_MASK = 'h50;
    localparam int REG_STEP = 4;
endpackage

// File: rtl/ivc_bank.sv
// One bank of interrupt lines: pending (level-set, write-one-to-clear),
// enable and mask registers. Assumes write strobes are already qualified
// by address and protection.
module ivc_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         wr_pend,
    input  logic         wr_en,
    input  logic         wr_mask,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] pend,
    output logic [W-1:0] en,
    output logic [W-1:0] mask
);
    logic [W-1:0] clr;

    // Bits to clear this cycle from a pending write.
    always_comb clr = wr_pend ? wdata : '0;

    // Pending latch: clear on one, then set from high inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | src;
    end

    // Enable and mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= '0;
            mask <= '0;
        end else begin
            if (wr_en)   en   <= wdata;
            if (wr_mask) mask <= wdata;
        end
    end
endmodule

// File: rtl/ivc_pick.sv
// Lowest-number picker over active lines 1..N-1. Line 0 is ignored.
// Assumes N is at least 2. idx is zero when valid is low.
module ivc_pick #(
    parameter int N     = 96,
    parameter int IDX_W = 7
) (
    input  logic [N-1:0]     active,
    output logic [IDX_W-1:0] idx,
    output logic             valid
);
    // Scan downward so the lowest active line is assigned last.
    always_comb begin
        idx   = '0;
        valid = 1'b0;
        for (int i = N - 1; i >= 1; i--) begin
            if (active[i]) begin
                idx   = IDX_W'(i);
                valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
// Banked vectored interrupt controller top: register decode, protection,
// read mux, vector encoding and the registered request output.
// Assumes single-cycle bus accesses; read data is returned one cycle later.
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int EXT_W     = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_BANKS*DATA_W-1:0]   src_i,
    input  logic                          bus_sel,
    input  logic                          bus_wr,
    input  logic                          bus_priv,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    output logic                          irq_o
);
    localparam int NSRC  = NUM_BANKS * DATA_W;
    localparam int IDX_W = $clog2(NSRC);

    logic [NSRC-1:0]   pend_all, en_all, mask_all, active;
    logic              prot_q;
    logic [EXT_W-1:0]  ext_q;
    logic              wr_ok;
    logic [IDX_W-1:0]  vec_idx;
    logic              vec_valid;
    logic [DATA_W-1:0] vec_word, rd_mux;

    // Write qualifier: protection blocks unprivileged writes.
    always_comb wr_ok = bus_sel && bus_wr && (!prot_q || bus_priv);

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        logic wp, we, wm;
        // Per-bank address decode.
        always_comb begin
            wp = wr_ok && (bus_addr == ADDR_W'(OFS_PEND + REG_STEP * k));
            we = wr_ok && (bus_addr == ADDR_W'(OFS_EN   + REG_STEP * k));
            wm = wr_ok && (bus_addr == ADDR_W'(OFS_MASK + REG_STEP * k));
        end
        ivc_bank #(.W(DATA_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (src_i[k*DATA_W +: DATA_W]),
            .wr_pend (wp),
            .wr_en   (we),
            .wr_mask (wm),
            .wdata   (bus_wdata),
            .pend    (pend_all[k*DATA_W +: DATA_W]),
            .en      (en_all[k*DATA_W +: DATA_W]),
            .mask    (mask_all[k*DATA_W +: DATA_W])
        );
    end

    // Control registers: protection bit and external-source field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= 1'b0;
            ext_q  <= '0;
        end else begin
            if (wr_ok && bus_addr == ADDR_W'(OFS_PROT)) prot_q <= bus_wdata[0];
            if (wr_ok && bus_addr == ADDR_W'(OFS_EXT))  ext_q  <= bus_wdata[EXT_W-1:0];
        end
    end

    // Lines eligible for service.
    always_comb active = pend_all & en_all & ~mask_all;

    ivc_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick (
        .active (active),
        .idx    (vec_idx),
        .valid  (vec_valid)
    );

    // Vector word: line number times four, zero when none.
    always_comb vec_word = vec_valid ? (DATA_W'(vec_idx) << 2) : '0;

    // Read multiplexer over all mapped registers.
    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(OFS_VEC))  rd_mux = vec_word;
        if (bus_addr == ADDR_W'(OFS_PROT)) rd_mux = DATA_W'(prot_q);
        if (bus_addr == ADDR_W'(OFS_EXT))  rd_mux = DATA_W'(ext_q);
        for (int k = 0; k < NUM_BANKS; k++) begin
            if (bus_addr == ADDR_W'(OFS_PEND + REG_STEP * k)) rd_mux = pend_all[k*DATA_W +: DATA_W];
            if (bus_addr == ADDR_W'(OFS_EN   + REG_STEP * k)) rd_mux = en_all[k*DATA_W +: DATA_W];
            if (bus_addr == ADDR_W'(OFS_MASK + REG_STEP * k)) rd_mux = mask_all[k*DATA_W +: DATA_W];
        end
    end

    // Registered read data and interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            irq_o     <= 1'b0;
        end else begin
            if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
            irq_o <= |active;
        end
    end
endmodule

// File: rtl/ivc_checker.sv
// Property checker for irq_vector_ctrl, attached by bind below.
// Assumes it sees the bank state and picker result of the top.
module ivc_checker #(
    parameter int NSRC  = 96,
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSRC-1:0]  src_i,
    input logic [NSRC-1:0]  pend,
    input logic [NSRC-1:0]  en,
    input logic [NSRC-1:0]  mask,
    input logic             prot,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic             bus_priv,
    input logic [IDX_W-1:0] vec_idx,
    input logic             vec_valid,
    input logic             irq_o
);
    logic [NSRC-1:0] act;
    always_comb act = pend & en & ~mask;

    a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|act)));

    a_r3_pend_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i != '0) |=> ((pend & $past(src_i)) == $past(src_i)));

    a_r7_winner_active: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (act[vec_idx] && vec_idx != '0));

    a_r7_none_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> ((act >> 1) == '0));

    a_r11_prot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && prot && !bus_priv) |=> ($stable(en) && $stable(mask) && prot));
endmodule

bind irq_vector_ctrl ivc_checker #(.NSRC(NSRC), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .pend      (pend_all),
    .en        (en_all),
    .mask      (mask_all),
    .prot      (prot_q),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_priv  (bus_priv),
    .vec_idx   (vec_idx),
    .vec_valid (vec_valid),
    .irq_o     (irq_o)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] src = '0;
    logic        sel = 1'b0, wr = 1'b0, priv = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    irq_vector_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel(sel), .bus_wr(wr),
        .bus_priv(priv), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .irq_o(irq)
    );

    // Monitor: note reads at the edge, compare against the queue half a cycle later.
    always @(posedge clk) rd_seen <= rst_n && sel && !wr;
    always @(negedge clk) begin
        if (rd_seen) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (rdata !== e) begin
                n_fail++;
                $display("FAIL %s: read got %h expected %h", t, rdata, e);
            end
        end
    end

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input logic p);
        sel = 1; wr = 1; priv = p; addr = a; wdata = d;
        @(negedge clk);
        sel = 0; wr = 0; priv = 0;
    endtask

    task automatic rd_reg(input logic [7:0] a, input logic [31:0] e, input string t);
        sel = 1; wr = 0; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_chk++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq got %b expected %b", t, irq, e);
        end
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        // R1 reset state
        chk_irq(1'b0, "R1 irq reset");
        rd_reg(8'h00, 32'h0, "R1 vector reset");
        rd_reg(8'h40, 32'h0, "R1 enable reset");
        rd_reg(8'h50, 32'h0, "R1 mask reset");
        rd_reg(8'h10, 32'h0, "R1 pending reset");
        rd_reg(8'h08, 32'h0, "R1 protection reset");
        // R3 latch without enable, R6 gating
        src[5] = 1;
        idle(1);
        rd_reg(8'h10, 32'h20, "R3 pending latched");
        rd_reg(8'h00, 32'h0, "R6 disabled not selected");
        chk_irq(1'b0, "R6 disabled no irq");
        // R5 vector encoding, R10 registered irq
        wr_reg(8'h40, 32'h20, 0);
        idle(1);
        chk_irq(1'b1, "R10 irq raised");
        rd_reg(8'h00, 32'd20, "R5 vector line 5");
        // R7 lowest wins, R2 bank mapping
        src[40] = 1; src[70] = 1;
        wr_reg(8'h44, 32'h100, 0);
        wr_reg(8'h48, 32'h40, 0);
        idle(1);
        rd_reg(8'h00, 32'd20, "R7 lowest of three");
        rd_reg(8'h14, 32'h100, "R2 line 40 in bank 1 bit 8");
        // R4 clear whole bank
        src[5] = 0;
        idle(1);
        wr_reg(8'h10, 32'hFFFF_FFFF, 0);
        rd_reg(8'h10, 32'h0, "R4 bank cleared");
        rd_reg(8'h00, 32'd160, "R5 vector line 40");
        // R8 level re-trigger
        wr_reg(8'h14, 32'h100, 0);
        rd_reg(8'h14, 32'h100, "R8 still pending");
        // R4 zero bits unchanged
        src[70] = 0;
        idle(1);
        wr_reg(8'h18, 32'h8, 0);
        rd_reg(8'h18, 32'h40, "R4 zero bit kept");
        // R9 mask
        wr_reg(8'h54, 32'h100, 0);
        rd_reg(8'h54, 32'h100, "R9 mask readback");
        rd_reg(8'h00, 32'd280, "R9 masked line skipped");
        wr_reg(8'h58, 32'h40, 0);
        rd_reg(8'h00, 32'h0, "R9 all masked vector zero");
        idle(1);
        chk_irq(1'b0, "R9 masked no irq");
        // R7 line 0 never reported, R10 still raises irq
        src[0] = 1;
        wr_reg(8'h40, 32'h1, 0);
        idle(2);
        rd_reg(8'h00, 32'h0, "R7 line 0 not reported");
        chk_irq(1'b1, "R10 line 0 raises irq");
        src[0] = 0;
        wr_reg(8'h10, 32'hFFFF_FFFF, 0);
        idle(2);
        chk_irq(1'b0, "R10 irq drops");
        // R11 protection
        wr_reg(8'h08, 32'h1, 0);
        rd_reg(8'h08, 32'h1, "R11 protection set");
        wr_reg(8'h40, 32'hFFFF_FFFF, 0);
        rd_reg(8'h40, 32'h1, "R11 unprivileged enable ignored");
        wr_reg(8'h08, 32'h0, 0);
        rd_reg(8'h08, 32'h1, "R11 unprivileged unprotect ignored");
        wr_reg(8'h40, 32'h22, 1);
        rd_reg(8'h40, 32'h22, "R11 privileged write taken");
        wr_reg(8'h08, 32'h0, 1);
        rd_reg(8'h08, 32'h0, "R11 privileged unprotect");
        // R12 external control, R2 unmapped read
        wr_reg(8'h0C, 32'hFFFF_FFFF, 0);
        rd_reg(8'h0C, 32'h3, "R12 two bits stored");
        rd_reg(8'h30, 32'h0, "R2 unmapped reads zero");
        idle(2);
        finish_run();
    end
endmodule